// File: doc/BRIEF.md
# Byte-Alterable Nonvolatile Store Sequencer

This block sits on the special-function-register bus of an 8-bit processor and gives it access to a 256-byte nonvolatile data store. The store is modelled as a register array together with a timed busy period. Software sets an address through two address registers. It reads bytes through a data register. It starts an alteration by writing that data register. A control register selects the operation: single-byte alteration, erase of one 8-byte row, or erase of the whole store.

Each erase or write phase lasts a programmable time. That time is a phase-length register multiplied by a fixed clock prescale. A byte alteration first looks at the old contents. It runs the erase phase only when the old byte is not 00h. When a sequence ends, the block raises a completion flag, which can be routed to an interrupt.

A 4-bit protection field sits at pseudo-address 8000h. A majority vote over this field gives a lock. When the lock is set and the processor runs from external program memory, the store is fenced off, and only a full erase can clear it. A power-saving request aborts any sequence in flight.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: After reset, address-high reads 80h, address-low reads 00h, the phase-length register reads 08h, control reads 00h, and `busy` and `irq` are low.
- R2: The register addresses are address-low F2h, address-high F3h, data F4h, phase length F5h and control F6h. Address and phase-length registers read back what was written. Any other address reads 00h. Read data appears on `sfr_rdata` after the clock edge that samples `sfr_re`.
- R3: In byte mode, a data read returns the following, provided the address was written at least two cycles earlier. With high address 00h it returns the store byte at the low address. At 80h/00h it returns the protection field zero-extended. Any other address reads 00h. Erased bytes read 00h.
- R4: Let T = max(phase length, 1) × PRESCALE cycles. A byte write whose old value is 00h keeps `busy` high on 1+T consecutive samples. Sampling starts on the cycle after the data write, and the new byte is then stored.
- R5: A byte write whose old value is not 00h runs an erase phase and then a write phase, so `busy` stays high on 1+2T samples.
- R6: With control mode 0Ch, a data write clears the 8 bytes whose addresses share the upper five bits of the low address. The written value is ignored and other bytes are untouched. `busy` stays high on 1+T+8 samples.
- R7: With control mode 0Ah, a data write clears every store byte and the protection field. The address and data values are ignored. `busy` stays high on 1+T+256 samples.
- R8: Control reads as {flag[7], enable[6], busy[5], 0[4], mode[3:0]}. The flag is set when a sequence completes. Software writes set or clear the flag and the enable. Bit 5 ignores writes. `irq` is high exactly when both the flag and the enable are set.
- R9: While busy, writes to the data, address and phase-length registers are dropped and are not queued. Data reads return 00h.
- R10: A byte write to 80h/00h stores the low 4 bits as the protection field. The lock is set when at least 3 of the 4 bits are set.
- R11: With the lock set and `ext_exec` high, data reads return 00h and data writes start nothing unless the mode is 0Ah. A completed full erase clears the lock.
- R12: `pwr_save` high on a busy cycle ends the sequence at that edge. The flag stays clear, and phases that have not finished leave the store unchanged.
- R13: A phase-length value of 00h acts as 01h, so T = PRESCALE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Register write strobe |
| sfr_re | input | 1 | Register read strobe |
| sfr_rdata | output | 8 | Registered read data |
| ext_exec | input | 1 | Processor is executing from external program memory |
| pwr_save | input | 1 | Idle or power-down request; aborts a running sequence |
| busy | output | 1 | Erase/write sequence in progress |
| irq | output | 1 | Completion interrupt request |

## Verification
Read data is due one edge after the read strobe. A data-register read needs the address stable for two edges, so the bench's read task always leaves one idle cycle before the strobe, and the scoreboard monitor compares on the falling edge after the sampling edge. Sequence lengths are measured by counting the falling-edge samples on which `busy` is high, starting with the first falling edge after the data write; the expected counts are 1+T, 1+2T, 1+T+8 and 1+T+256. An abort is checked at the first falling edge after the edge on which `pwr_save` was sampled, and `busy` must already be low there.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {OP_BYTE, OP_ROW, OP_BLOCK} nvm_op_e;

  localparam logic [7:0] SFR_ADR_LO = 8'hF2;
  localparam logic [7:0] SFR_ADR_HI = 8'hF3;
  localparam logic [7:0] SFR_DATA   = 8'hF4;
  localparam logic [7:0] SFR_TIMER  = 8'hF5;
  localparam logic [7:0] SFR_CTRL   = 8'hF6;

  localparam logic [3:0] MODE_BYTE  = 4'h0;
  localparam logic [3:0] MODE_ROW   = 4'hC;
  localparam logic [3:0] MODE_BLOCK = 4'hA;

  localparam logic [7:0] PROT_HI    = 8'h80;
  localparam logic [7:0] PROT_LO    = 8'h00;
  localparam logic [7:0] TIMER_RST  = 8'h08;
endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
  parameter int PRESCALE = 4,
  parameter int TIMER_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [TIMER_W-1:0] limit,
  output logic               done
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [TIMER_W-1:0] tk_q;
  logic [TIMER_W-1:0] lim_eff;
  logic               tick;

  // a zero length is treated as one tick
  assign lim_eff = (limit == '0) ? TIMER_W'(1) : limit;
  assign done    = run && tick && (tk_q == lim_eff - TIMER_W'(1));

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] sub_q;
      assign tick = (sub_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (rst || !run || done) sub_q <= '0;
        else if (tick)           sub_q <= '0;
        else                     sub_q <= sub_q + PW'(1);
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run || done) tk_q <= '0;
    else if (tick)           tk_q <= tk_q + TIMER_W'(1);
  end

  // R13: tick count never passes the effective length
  a_r13_tick_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (tk_q < lim_eff));
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int DEPTH    = 256,
  parameter int SEC_BITS = 4,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic [AW-1:0]       rd_addr,
  output logic [7:0]          rd_data,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [7:0]          wdata,
  input  logic                sec_we,
  input  logic [SEC_BITS-1:0] sec_wdata,
  output logic [SEC_BITS-1:0] sec_bits
);
  logic [7:0]          mem [DEPTH];
  logic [SEC_BITS-1:0] sec_q = '0;

  // nonvolatile contents start erased and are not touched by reset
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (sec_we) sec_q <= sec_wdata;
  end

  assign sec_bits = sec_q;
endmodule

// File: rtl/nvm_sequencer.sv
module nvm_sequencer
  import nvm_seq_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int ROW_BYTES = 8,
  parameter int SEC_BITS  = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int RW       = $clog2(ROW_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  nvm_op_e             op,
  input  logic                tgt_sec,
  input  logic [7:0]          wr_val,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          old_val,
  input  logic                tmr_done,
  input  logic                abort,
  output logic                busy,
  output logic                phase_run,
  output logic                seq_done,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [7:0]          mem_wdata,
  output logic                sec_we,
  output logic [SEC_BITS-1:0] sec_wdata
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_ERASE, S_WRITE, S_SWEEP} seq_st_e;

  seq_st_e       state_q, state_d;
  nvm_op_e       op_q;
  logic          tgt_q;
  logic [7:0]    val_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] idx_q, idx_d;
  logic [AW-1:0] sweep_first;
  logic          sweep_last;

  assign sweep_first = (op_q == OP_ROW) ? {addr_q[AW-1:RW], {RW{1'b0}}} : '0;
  assign sweep_last  = (op_q == OP_ROW) ? (&idx_q[RW-1:0]) : (&idx_q);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    mem_we    = 1'b0;
    mem_waddr = addr_q;
    mem_wdata = 8'h00;
    sec_we    = 1'b0;
    sec_wdata = '0;
    seq_done  = 1'b0;
    case (state_q)
      S_IDLE:  if (start) state_d = S_CHECK;
      S_CHECK: begin
        if (op_q == OP_BYTE && old_val == 8'h00) state_d = S_WRITE;
        else                                     state_d = S_ERASE;
      end
      S_ERASE: if (tmr_done) begin
        if (op_q == OP_BYTE) begin
          mem_we  = !tgt_q;
          sec_we  = tgt_q;
          state_d = S_WRITE;
        end else begin
          sec_we  = (op_q == OP_BLOCK);
          idx_d   = sweep_first;
          state_d = S_SWEEP;
        end
      end
      S_WRITE: if (tmr_done) begin
        mem_we    = !tgt_q;
        mem_wdata = val_q;
        sec_we    = tgt_q;
        sec_wdata = val_q[SEC_BITS-1:0];
        seq_done  = 1'b1;
        state_d   = S_IDLE;
      end
      S_SWEEP: begin
        mem_we    = 1'b1;
        mem_waddr = idx_q;
        if (sweep_last) begin
          seq_done = 1'b1;
          state_d  = S_IDLE;
        end else begin
          idx_d = idx_q + AW'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (abort && state_q != S_IDLE) begin
      state_d  = S_IDLE;
      mem_we   = 1'b0;
      sec_we   = 1'b0;
      seq_done = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      op_q    <= OP_BYTE;
      tgt_q   <= 1'b0;
      val_q   <= 8'h00;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (state_q == S_IDLE && start) begin
        op_q   <= op;
        tgt_q  <= tgt_sec;
        val_q  <= wr_val;
        addr_q <= addr;
      end
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign phase_run = (state_q == S_ERASE) || (state_q == S_WRITE);

  // R12: a power-saving request ends the sequence at once
  a_r12_abort_idles: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE && abort) |=> (state_q == S_IDLE));
  // R4: byte sequences never enter the clearing sweep
  a_r4_byte_no_sweep: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SWEEP) |-> (op_q != OP_BYTE));
  // R6: a row sweep stays inside the latched row
  a_r6_sweep_in_row: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SWEEP && op_q == OP_ROW) |-> (idx_q[AW-1:RW] == addr_q[AW-1:RW]));
endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int ROW_BYTES = 8,
  parameter int PRESCALE  = 4,
  parameter int SEC_BITS  = 4,
  parameter int SEC_VOTE  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_we,
  input  logic       sfr_re,
  output logic [7:0] sfr_rdata,
  input  logic       ext_exec,
  input  logic       pwr_save,
  output logic       busy,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] ah_q, al_q, tim_q;
  logic       flag_q, en_q;
  logic [3:0] mode_q;
  logic [7:0] rdata_q, rd_mux, data_view;

  logic [7:0]          mem_q;
  logic [SEC_BITS-1:0] sec_bits;
  logic [7:0]          sec_ext;
  logic                mem_we, sec_we, seq_done, phase_run, tmr_done, busy_w;
  logic [AW-1:0]       mem_waddr;
  logic [7:0]          mem_wdata;
  logic [SEC_BITS-1:0] sec_wdata;

  logic    arr_sel, sec_sel, locked, op_ok, start;
  nvm_op_e op;
  logic    wr_lo, wr_hi, wr_data, wr_tim, wr_ctrl;

  assign wr_lo   = sfr_we && (sfr_addr == SFR_ADR_LO);
  assign wr_hi   = sfr_we && (sfr_addr == SFR_ADR_HI);
  assign wr_data = sfr_we && (sfr_addr == SFR_DATA);
  assign wr_tim  = sfr_we && (sfr_addr == SFR_TIMER);
  assign wr_ctrl = sfr_we && (sfr_addr == SFR_CTRL);

  assign arr_sel = (ah_q == 8'h00) && ({24'b0, al_q} < DEPTH);
  assign sec_sel = (ah_q == PROT_HI) && (al_q == PROT_LO);
  assign sec_ext = {{(8 - SEC_BITS){1'b0}}, sec_bits};
  assign locked  = ($countones(sec_bits) >= SEC_VOTE) && ext_exec;

  always_comb begin
    op_ok = 1'b1;
    op    = OP_BYTE;
    case (mode_q)
      MODE_BYTE:  op = OP_BYTE;
      MODE_ROW:   op = OP_ROW;
      MODE_BLOCK: op = OP_BLOCK;
      default:    op_ok = 1'b0;
    endcase
  end

  assign start = wr_data && !busy_w && op_ok
               && (!locked || op == OP_BLOCK)
               && (op != OP_BYTE || arr_sel || sec_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ah_q   <= PROT_HI;
      al_q   <= PROT_LO;
      tim_q  <= TIMER_RST;
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= MODE_BYTE;
    end else begin
      if (wr_lo  && !busy_w) al_q  <= sfr_wdata;
      if (wr_hi  && !busy_w) ah_q  <= sfr_wdata;
      if (wr_tim && !busy_w) tim_q <= sfr_wdata;
      if (wr_ctrl) begin
        flag_q <= sfr_wdata[7];
        en_q   <= sfr_wdata[6];
        mode_q <= sfr_wdata[3:0];
      end
      if (seq_done) flag_q <= 1'b1;
    end
  end

  always_comb begin
    if (busy_w || locked) data_view = 8'h00;
    else if (sec_sel)     data_view = sec_ext;
    else if (arr_sel)     data_view = mem_q;
    else                  data_view = 8'h00;
  end

  always_comb begin
    case (sfr_addr)
      SFR_ADR_LO: rd_mux = al_q;
      SFR_ADR_HI: rd_mux = ah_q;
      SFR_DATA:   rd_mux = data_view;
      SFR_TIMER:  rd_mux = tim_q;
      SFR_CTRL:   rd_mux = {flag_q, en_q, busy_w, 1'b0, mode_q};
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (sfr_re) rdata_q <= rd_mux;
  end

  nvm_phase_timer #(.PRESCALE(PRESCALE), .TIMER_W(8)) u_timer (
    .clk(clk), .rst(rst), .run(phase_run), .limit(tim_q), .done(tmr_done)
  );

  nvm_store #(.DEPTH(DEPTH), .SEC_BITS(SEC_BITS)) u_store (
    .clk(clk), .rd_addr(al_q[AW-1:0]), .rd_data(mem_q),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .sec_we(sec_we), .sec_wdata(sec_wdata), .sec_bits(sec_bits)
  );

  nvm_sequencer #(.DEPTH(DEPTH), .ROW_BYTES(ROW_BYTES), .SEC_BITS(SEC_BITS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .tgt_sec(sec_sel),
    .wr_val(sfr_wdata), .addr(al_q[AW-1:0]),
    .old_val(sec_sel ? sec_ext : mem_q),
    .tmr_done(tmr_done), .abort(pwr_save),
    .busy(busy_w), .phase_run(phase_run), .seq_done(seq_done),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .sec_we(sec_we), .sec_wdata(sec_wdata)
  );

  assign sfr_rdata = rdata_q;
  assign busy      = busy_w;
  assign irq       = flag_q && en_q;

  // R9: address and phase-length registers hold while a sequence runs
  a_r9_regs_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(busy_w) |-> ($stable(al_q) && $stable(ah_q) && $stable(tim_q)));
  // R11: a locked, non-erase data write starts nothing
  a_r11_locked_no_start: assert property (@(posedge clk) disable iff (rst)
    (!busy_w && locked && wr_data && mode_q != MODE_BLOCK) |=> !busy_w);
  // R8: a sequence that ends without abort leaves the flag set
  a_r8_flag_on_finish: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_w) && !$past(pwr_save)) |-> flag_q);
  // R12: an aborted sequence does not raise the flag by itself
  a_r12_no_flag_on_abort: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_w) && $past(pwr_save) && !$past(flag_q) && !$past(wr_ctrl)) |-> !flag_q);
endmodule

// File: tb/tb_nvm_seq_ctrl.sv
module tb_nvm_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 4;
  localparam int DEPTH      = 256;
  localparam int ROWB       = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0, sfr_re = 1'b0;
  logic [7:0] sfr_rdata;
  logic       ext_exec = 1'b0, pwr_save = 1'b0;
  logic       busy, irq;

  int n_cmp = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  re_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_seq_ctrl #(.DEPTH(DEPTH), .ROW_BYTES(ROWB), .PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata),
    .ext_exec(ext_exec), .pwr_save(pwr_save), .busy(busy), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) re_d <= sfr_re;
  always @(negedge clk) begin
    if (re_d) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), int'(sfr_rdata), exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    @(negedge clk);
    sfr_addr = a; sfr_re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    sfr_re = 1'b0;
  endtask

  task automatic busy_len(output int cnt);
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    wr(8'hF2, lo);
    wr(8'hF3, hi);
  endtask

  task automatic wait_idle();
    int c;
    busy_len(c);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int c;
    int t;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy after reset", busy, 0);
    check("R1 irq after reset", irq, 0);
    rd(8'hF3, 8'h80, "R1 address high reset");
    rd(8'hF2, 8'h00, "R1 address low reset");
    rd(8'hF5, 8'h08, "R1 phase length reset");
    rd(8'hF6, 8'h00, "R1 control reset");

    // R2 map and readback
    wr(8'hF5, 8'h02);
    t = 2 * PRESCALE;
    rd(8'hF5, 8'h02, "R2 phase length readback");
    set_addr(8'h00, 8'h10);
    rd(8'hF2, 8'h10, "R2 address low readback");
    rd(8'hF3, 8'h00, "R2 address high readback");
    rd(8'h81, 8'h00, "R2 unmapped reads zero");
    rd(8'hF4, 8'h00, "R3 erased byte reads 00");

    // R4 write-only byte
    wr(8'hF4, 8'hA5);
    busy_len(c);
    check("R4 write-only busy length", c, 1 + t);
    rd(8'hF4, 8'hA5, "R3 byte read after write");
    rd(8'hF6, 8'h80, "R8 flag set at completion");
    check("R8 irq masked when disabled", irq, 0);
    wr(8'hF6, 8'h40);
    rd(8'hF6, 8'h40, "R8 flag cleared by software");

    // R5 erase plus write
    wr(8'hF4, 8'h3C);
    busy_len(c);
    check("R5 erase+write busy length", c, 1 + 2 * t);
    rd(8'hF4, 8'h3C, "R5 new byte stored");
    check("R8 irq when flag and enable", irq, 1);
    wr(8'hF6, 8'h40);
    check("R8 irq low after flag cleared", irq, 0);
    wr(8'hF6, 8'h20);
    rd(8'hF6, 8'h00, "R8 busy bit ignores writes");
    wr(8'hF6, 8'h40);

    // R9 accesses while busy (long phase)
    wr(8'hF5, 8'h08);
    wr(8'hF2, 8'h11);
    wr(8'hF4, 8'h77);
    wr(8'hF4, 8'h55);
    wr(8'hF2, 8'h20);
    wr(8'hF5, 8'h07);
    rd(8'hF6, 8'h60, "R8 busy bit reads 1 while busy");
    rd(8'hF4, 8'h00, "R9 data read while busy");
    wait_idle();
    rd(8'hF2, 8'h11, "R9 address write dropped while busy");
    rd(8'hF5, 8'h08, "R9 phase length write dropped while busy");
    rd(8'hF4, 8'h77, "R9 second data write dropped");
    wr(8'hF5, 8'h02);

    // R6 row erase
    wr(8'hF2, 8'h18); wr(8'hF4, 8'h11); wait_idle();
    wr(8'hF2, 8'h17); wr(8'hF4, 8'h33); wait_idle();
    wr(8'hF2, 8'h20); wr(8'hF4, 8'h22); wait_idle();
    wr(8'hF2, 8'h1C);
    wr(8'hF6, 8'h4C);
    wr(8'hF4, 8'hFF);
    busy_len(c);
    check("R6 row erase busy length", c, 1 + t + ROWB);
    wr(8'hF6, 8'h40);
    wr(8'hF2, 8'h18); rd(8'hF4, 8'h00, "R6 row byte cleared");
    wr(8'hF2, 8'h17); rd(8'hF4, 8'h33, "R6 byte below row untouched");
    wr(8'hF2, 8'h20); rd(8'hF4, 8'h22, "R6 byte above row untouched");
    wr(8'hF2, 8'h10); rd(8'hF4, 8'h3C, "R6 distant byte untouched");

    // R13 zero phase length
    wr(8'hF5, 8'h00);
    wr(8'hF2, 8'h30);
    wr(8'hF4, 8'h01);
    busy_len(c);
    check("R13 zero length acts as one", c, 1 + PRESCALE);
    wr(8'hF5, 8'h02);
    rd(8'hF4, 8'h01, "R13 byte stored");

    // R12 abort
    wr(8'hF6, 8'h40);
    wr(8'hF2, 8'h10);
    wr(8'hF4, 8'h99);
    @(negedge clk);
    @(negedge clk);
    pwr_save = 1'b1;
    @(negedge clk);
    pwr_save = 1'b0;
    check("R12 busy drops on abort", busy, 0);
    rd(8'hF6, 8'h40, "R12 flag not set by abort");
    rd(8'hF4, 8'h3C, "R12 byte unchanged after abort");

    // R10 / R11 protection field
    set_addr(8'h80, 8'h00);
    wr(8'hF4, 8'h0F); wait_idle();
    rd(8'hF4, 8'h0F, "R10 protection field stored");
    ext_exec = 1'b1;
    rd(8'hF4, 8'h00, "R11 locked data read");
    wr(8'hF4, 8'h00);
    check("R11 locked write starts nothing", busy, 0);
    ext_exec = 1'b0;
    rd(8'hF4, 8'h0F, "R11 field unchanged by locked write");
    wr(8'hF4, 8'h07); wait_idle();
    ext_exec = 1'b1;
    rd(8'hF4, 8'h00, "R10 three of four bits lock");
    ext_exec = 1'b0;
    wr(8'hF4, 8'h03); wait_idle();
    ext_exec = 1'b1;
    rd(8'hF4, 8'h03, "R10 two bits leave unlocked");
    ext_exec = 1'b0;
    wr(8'hF4, 8'h0F); wait_idle();
    ext_exec = 1'b1;

    // R7 block erase while locked
    wr(8'hF6, 8'h4A);
    wr(8'hF4, 8'h5A);
    busy_len(c);
    check("R7 block erase busy length", c, 1 + t + DEPTH);
    wr(8'hF6, 8'h40);
    wr(8'hF4, 8'h01);
    check("R11 block erase cleared lock", busy, 1);
    wait_idle();
    rd(8'hF4, 8'h01, "R11 unlocked write stored");
    ext_exec = 1'b0;
    set_addr(8'h00, 8'h10);
    rd(8'hF4, 8'h00, "R7 byte 10h cleared");
    wr(8'hF2, 8'h30);
    rd(8'hF4, 8'h00, "R7 byte 30h cleared");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule